// File: doc/BRIEF.md
# Spare-Row Repair Analyzer

This block sits beside a memory self-test engine and turns its stream of word compare results into a spare-row repair plan while the test runs. For every word the engine reads back, the analyzer sees one compare strobe, one pass/fail flag for the whole word and the word address. Only the upper address bits that select a physical row are kept. A failing word whose row already has a spare costs nothing more. A failing word on a new row claims the lowest-numbered free spare row. A failing word on a new row with no spare left marks the memory as beyond repair.

Every counted miscompare goes into an error counter. The counter is compared with a limit that is loaded before the run, and the analyzer stops accepting failures once the counter reaches that limit. A done strobe from the test engine freezes the result. A synchronous clear prepares the analyzer for the next run. When the test ends, the status code and the table of allocated rows are already final and can be used directly to steer the redundancy.

Top module: `row_repair_analyzer`

## Requirements
- R1: After reset, `status` is 00, `spare_valid` is all zero, `err_count` is 0 and `halt` is 0. The `status` output never shows the value 11.
- R2: A counted failure on a row that no spare holds, while a spare is free, sets `status` to 01 (repair needed). If `status` was already 10, it stays 10. The same failure stores the row number `cmp_addr[ADDR_W-1:ADDR_W-ROW_W]` in the free entry.
- R3: The low `ADDR_W-ROW_W` address bits (the column bits) play no part in row matching. A failure in a row that a spare already holds leaves the entries, their valid bits and `status` unchanged. It still increments `err_count`.
- R4: Spares are handed out in index order, so entry i occupies bits `[i*ROW_W +: ROW_W]` of `spare_rows`. A set bit in `spare_valid` always has every lower bit set as well.
- R5: A counted failure on a new row when every spare is taken sets `status` to 10 (not repairable). This code stays until the next clear, and the spare entries do not change.
- R6: A cycle with `cmp_valid` low, or with `cmp_fail` low, changes no output.
- R7: Each counted failure adds one to `err_count`. When `err_count` reaches a nonzero `err_limit`, `halt` rises and every later failure is ignored until the next clear.
- R8: An `err_limit` of 0 means there is no limit. In that case `err_count` saturates at its maximum value and `halt` stays low.
- R9: A failure in the same cycle as `done`, or in any cycle after it, is ignored. The freeze holds until the next clear.
- R10: `clr` wins over every other input. It returns the status, the entries, the valid bits, the counter, `halt` and the freeze to their reset values.
- R11: Every result appears on the outputs at the first rising clock edge after the input cycle that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear before a new run |
| cmp_valid | input | 1 | A compare result is present this cycle |
| cmp_fail | input | 1 | The word compare missed |
| cmp_addr | input | ADDR_W | Word address of the compare |
| done | input | 1 | The test engine has finished |
| err_limit | input | CNT_W | Miscompare limit; 0 means no limit |
| status | output | 2 | 00 clean, 01 repair needed, 10 not repairable |
| spare_valid | output | NUM_SPARES | Allocation flag per spare entry |
| spare_rows | output | NUM_SPARES*ROW_W | Row number held by each entry |
| err_count | output | CNT_W | Counted miscompares |
| halt | output | 1 | The miscompare limit has been reached |

## Verification
Every output of this block comes from a single register stage. The status, the entries, the counter and halt therefore all reflect a given compare cycle at the first rising edge after it. The bench drives each input cycle on the falling edge, lets exactly one rising edge pass, and checks all outputs at the following falling edge, before it drives the next cycle. In a cycle where the input is ignored (after done, after halt, or on a pass), the bench checks at that same point that nothing moved.

// File: rtl/rra_pkg.sv
package rra_pkg;
    typedef enum logic [1:0] {
        RS_CLEAN     = 2'b00,
        RS_FIXABLE   = 2'b01,
        RS_UNFIXABLE = 2'b10
    } rstat_e;
endpackage

// File: rtl/rra_row_cam.sv
module rra_row_cam #(
    parameter int NUM_SPARES = 2,
    parameter int ROW_W      = 6
) (
    input  logic [NUM_SPARES-1:0]       ent_valid,
    input  logic [NUM_SPARES*ROW_W-1:0] ent_rows,
    input  logic [ROW_W-1:0]            row,
    output logic                        hit,
    output logic                        has_free,
    output logic [NUM_SPARES-1:0]       free_oh
);
    logic [NUM_SPARES-1:0] match;

    // one comparator per spare entry
    for (genvar g = 0; g < NUM_SPARES; g++) begin : g_cmp
        assign match[g] = ent_valid[g] && (ent_rows[g*ROW_W +: ROW_W] == row);
    end

    assign hit      = |match;
    assign has_free = ~&ent_valid;

    // lowest-index free entry
    always_comb begin
        free_oh = '0;
        for (int i = NUM_SPARES - 1; i >= 0; i--) begin
            if (!ent_valid[i]) free_oh = NUM_SPARES'(1) << i;
        end
    end
endmodule

// File: rtl/rra_err_limit.sv
module rra_err_limit #(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] count_inc,
    output logic             reach
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    assign count_inc = (count == CNT_MAX) ? count : count + CNT_W'(1);
    assign reach     = (limit != '0) && (count_inc == limit);
endmodule

// File: rtl/row_repair_analyzer.sv
module row_repair_analyzer
    import rra_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int ROW_W      = 6,
    parameter int NUM_SPARES = 2,
    parameter int CNT_W      = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr,
    input  logic                        cmp_valid,
    input  logic                        cmp_fail,
    input  logic [ADDR_W-1:0]           cmp_addr,
    input  logic                        done,
    input  logic [CNT_W-1:0]            err_limit,
    output logic [1:0]                  status,
    output logic [NUM_SPARES-1:0]       spare_valid,
    output logic [NUM_SPARES*ROW_W-1:0] spare_rows,
    output logic [CNT_W-1:0]            err_count,
    output logic                        halt
);
    localparam int ROW_LSB = ADDR_W - ROW_W;

    typedef struct packed {
        rstat_e                        st;
        logic [NUM_SPARES-1:0]         vld;
        logic [NUM_SPARES*ROW_W-1:0]   rows;
        logic [CNT_W-1:0]              cnt;
        logic                          halt;
        logic                          frozen;
    } state_t;

    state_t s_d, s_q;

    logic [ROW_W-1:0]      row;
    logic                  hit, has_free, reach;
    logic [NUM_SPARES-1:0] free_oh;
    logic [CNT_W-1:0]      cnt_inc;
    logic                  take;

    assign row = cmp_addr[ADDR_W-1:ROW_LSB];

    rra_row_cam #(.NUM_SPARES(NUM_SPARES), .ROW_W(ROW_W)) u_cam (
        .ent_valid (s_q.vld),
        .ent_rows  (s_q.rows),
        .row       (row),
        .hit       (hit),
        .has_free  (has_free),
        .free_oh   (free_oh)
    );

    rra_err_limit #(.CNT_W(CNT_W)) u_lim (
        .count     (s_q.cnt),
        .limit     (err_limit),
        .count_inc (cnt_inc),
        .reach     (reach)
    );

    assign take = cmp_valid && cmp_fail && !done && !s_q.frozen && !s_q.halt;

    always_comb begin
        s_d = s_q;
        if (done) s_d.frozen = 1'b1;
        if (take) begin
            s_d.cnt = cnt_inc;
            if (reach) s_d.halt = 1'b1;
            if (!hit) begin
                if (has_free) begin
                    for (int i = 0; i < NUM_SPARES; i++) begin
                        if (free_oh[i]) begin
                            s_d.vld[i]                  = 1'b1;
                            s_d.rows[i*ROW_W +: ROW_W]  = row;
                        end
                    end
                    if (s_q.st == RS_CLEAN) s_d.st = RS_FIXABLE;
                end else begin
                    s_d.st = RS_UNFIXABLE;
                end
            end
        end
        if (clr) begin
            s_d.st     = RS_CLEAN;
            s_d.vld    = '0;
            s_d.rows   = '0;
            s_d.cnt    = '0;
            s_d.halt   = 1'b0;
            s_d.frozen = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st     <= RS_CLEAN;
            s_q.vld    <= '0;
            s_q.rows   <= '0;
            s_q.cnt    <= '0;
            s_q.halt   <= 1'b0;
            s_q.frozen <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign status      = s_q.st;
    assign spare_valid = s_q.vld;
    assign spare_rows  = s_q.rows;
    assign err_count   = s_q.cnt;
    assign halt        = s_q.halt;
endmodule

// File: rtl/rra_checker.sv
module rra_checker #(
    parameter int ADDR_W     = 10,
    parameter int ROW_W      = 6,
    parameter int NUM_SPARES = 2,
    parameter int CNT_W      = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        clr,
    input logic                        cmp_valid,
    input logic                        cmp_fail,
    input logic                        done,
    input logic [1:0]                  status,
    input logic [NUM_SPARES-1:0]       spare_valid,
    input logic [NUM_SPARES*ROW_W-1:0] spare_rows,
    input logic [CNT_W-1:0]            err_count,
    input logic                        halt
);
    assert_status_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
        status != 2'b11);

    assert_fixable_has_spare_R2: assert property (@(posedge clk) disable iff (!rst_n)
        status == 2'b01 |-> spare_valid != '0);

    assert_fill_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((spare_valid + NUM_SPARES'(1)) & spare_valid) == '0);

    assert_unfix_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'b10 && !clr) |=> status == 2'b10);

    assert_valid_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (spare_valid & $past(spare_valid)) == $past(spare_valid));

    assert_pass_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !(cmp_valid && cmp_fail)) |=>
            $stable(err_count) && $stable(status) && $stable(spare_rows));

    assert_halt_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !clr) |=> $stable(err_count) && $stable(spare_valid) && halt);

    assert_done_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clr) |=> $stable(err_count) && $stable(spare_rows));

    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> status == 2'b00 && spare_valid == '0 && err_count == '0 && !halt);
endmodule

bind row_repair_analyzer rra_checker #(
    .ADDR_W(ADDR_W), .ROW_W(ROW_W), .NUM_SPARES(NUM_SPARES), .CNT_W(CNT_W)
) u_rra_checker (
    .clk(clk), .rst_n(rst_n), .clr(clr), .cmp_valid(cmp_valid),
    .cmp_fail(cmp_fail), .done(done), .status(status),
    .spare_valid(spare_valid), .spare_rows(spare_rows),
    .err_count(err_count), .halt(halt)
);

// File: tb/test_row_repair_analyzer.sv
module test_row_repair_analyzer;
    localparam int ADDR_W = 10, ROW_W = 6, NS = 2, CNT_W = 8;

    logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0;
    logic cmp_valid = 1'b0, cmp_fail = 1'b0, done = 1'b0;
    logic [ADDR_W-1:0] cmp_addr = '0;
    logic [CNT_W-1:0]  err_limit = '0;
    logic [1:0]        status;
    logic [NS-1:0]     spare_valid;
    logic [NS*ROW_W-1:0] spare_rows;
    logic [CNT_W-1:0]  err_count;
    logic              halt;
    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    row_repair_analyzer #(.ADDR_W(ADDR_W), .ROW_W(ROW_W), .NUM_SPARES(NS), .CNT_W(CNT_W))
    i_row_repair_analyzer (
        .clk(clk), .rst_n(rst_n), .clr(clr), .cmp_valid(cmp_valid),
        .cmp_fail(cmp_fail), .cmp_addr(cmp_addr), .done(done),
        .err_limit(err_limit), .status(status), .spare_valid(spare_valid),
        .spare_rows(spare_rows), .err_count(err_count), .halt(halt)
    );

    // {clr, vld, fail, addr[9:0], exp_status, exp_valid, exp_count, exp_rows}
    localparam int NV = 11;
    localparam logic [36:0] VEC [NV] = '{
        {1'b0,1'b1,1'b0,10'h3F5,2'b00,2'b00,8'd0,12'h000}, // R6 pass
        {1'b0,1'b0,1'b1,10'h100,2'b00,2'b00,8'd0,12'h000}, // R6 no strobe
        {1'b0,1'b1,1'b1,10'h2A3,2'b01,2'b01,8'd1,12'h02A}, // R2 first row
        {1'b0,1'b1,1'b1,10'h2AC,2'b01,2'b01,8'd2,12'h02A}, // R3 same row
        {1'b0,1'b1,1'b1,10'h051,2'b01,2'b11,8'd3,12'h16A}, // R4 second row
        {1'b0,1'b1,1'b1,10'h05F,2'b01,2'b11,8'd4,12'h16A}, // R3 hit entry 1
        {1'b0,1'b1,1'b1,10'h3F0,2'b10,2'b11,8'd5,12'h16A}, // R5 overflow
        {1'b0,1'b1,1'b1,10'h2A0,2'b10,2'b11,8'd6,12'h16A}, // R5 sticky
        {1'b0,1'b1,1'b0,10'h3F0,2'b10,2'b11,8'd6,12'h16A}, // R6 pass
        {1'b1,1'b1,1'b1,10'h3F0,2'b00,2'b00,8'd0,12'h000}, // R10 clr wins
        {1'b0,1'b1,1'b1,10'h000,2'b01,2'b01,8'd1,12'h000}  // R2 row zero
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive one cycle at negedge, pass one rising edge, return at next negedge
    task automatic cyc(input logic c, input logic v, input logic f, input logic [ADDR_W-1:0] a,
                       input logic d);
        clr = c; cmp_valid = v; cmp_fail = f; cmp_addr = a; done = d;
        @(posedge clk);
        @(negedge clk);
        clr = 1'b0; cmp_valid = 1'b0; cmp_fail = 1'b0; done = 1'b0;
    endtask

    task automatic expect_all(input string req, input logic [1:0] st, input logic [NS-1:0] vm,
                              input logic [CNT_W-1:0] cnt, input logic h);
        check({req, " status"}, 32'(status), 32'(st));
        check({req, " valid"}, 32'(spare_valid), 32'(vm));
        check({req, " count"}, 32'(err_count), 32'(cnt));
        check({req, " halt"}, 32'(halt), 32'(h));
    endtask

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_all("R1 reset", 2'b00, 2'b00, 8'd0, 1'b0);

        // R11: every vector result is checked one rising edge after drive
        for (int k = 0; k < NV; k++) begin
            cyc(VEC[k][36], VEC[k][35], VEC[k][34], VEC[k][33:24], 1'b0);
            check($sformatf("R11 vec%0d status", k), 32'(status), 32'(VEC[k][23:22]));
            check($sformatf("R11 vec%0d valid", k), 32'(spare_valid), 32'(VEC[k][21:20]));
            check($sformatf("R11 vec%0d count", k), 32'(err_count), 32'(VEC[k][19:12]));
            check($sformatf("R11 vec%0d rows", k), 32'(spare_rows), 32'(VEC[k][11:0]));
        end

        // R7: limit of 3 then ignore
        err_limit = 8'd3;
        cyc(1, 0, 0, '0, 0);
        cyc(0, 1, 1, 10'h2A3, 0);
        cyc(0, 1, 1, 10'h2A5, 0);
        expect_all("R7 before limit", 2'b01, 2'b01, 8'd2, 1'b0);
        cyc(0, 1, 1, 10'h051, 0);
        expect_all("R7 at limit", 2'b01, 2'b11, 8'd3, 1'b1);
        cyc(0, 1, 1, 10'h3F0, 0);
        expect_all("R7 after halt", 2'b01, 2'b11, 8'd3, 1'b1);
        check("R7 rows kept", 32'(spare_rows), 32'h16A);

        // R8: no limit, saturation
        err_limit = 8'd0;
        cyc(1, 0, 0, '0, 0);
        for (int k = 0; k < 260; k++) cyc(0, 1, 1, 10'h2A0, 0);
        expect_all("R8 saturate", 2'b01, 2'b01, 8'd255, 1'b0);

        // R9: done freezes
        cyc(1, 0, 0, '0, 0);
        cyc(0, 1, 1, 10'h100, 0);
        expect_all("R9 pre-done", 2'b01, 2'b01, 8'd1, 1'b0);
        cyc(0, 1, 1, 10'h200, 1);
        expect_all("R9 same cycle", 2'b01, 2'b01, 8'd1, 1'b0);
        cyc(0, 1, 1, 10'h200, 0);
        expect_all("R9 after done", 2'b01, 2'b01, 8'd1, 1'b0);
        check("R9 rows", 32'(spare_rows), 32'h010);

        // R10: clear releases the freeze
        cyc(1, 0, 0, '0, 0);
        expect_all("R10 clear", 2'b00, 2'b00, 8'd0, 1'b0);
        cyc(0, 1, 1, 10'h200, 0);
        expect_all("R10 reuse", 2'b01, 2'b01, 8'd1, 1'b0);
        check("R10 rows", 32'(spare_rows), 32'h020);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule